// File: doc/BRIEF.md
# Reset and Operating Mode Controller

This block decides which of four operating modes the processor is in: held in reset, running normally, running with a reduced clock to save power, or stopped. Four reset-request inputs cover power-on/power-fail, the external reset pin, a watchdog timeout and an internal system reset. Any one of them forces the reset mode. From that mode the block releases the core synchronously, a fixed number of cycles after the last request has gone away. It then hands the core a fixed restart address in utility ROM.

Outside reset, a level request moves the core between normal running and the reduced-clock mode. A stop request gates every clock and halts the core, with one exception: the wake-up timer clock stays on if that timer is enabled. An external wake stimulus ends the stop and returns the core to the mode it left. A cause register records which source produced the most recent reset. The clock divider, the watchdog counter and analog power detection sit outside this block and appear here only as pulses and selects.

Top module: `rstmode_ctrl`

## Requirements
- R1: A high on any reset-request input (`rq_power`, `rq_pin`, `rq_wdog`, `rq_soft`) at a clock edge puts `mode_o` to RESET (code 0) after that edge. The asynchronous `rst_n` low also forces RESET. Mode codes are 0 RESET, 1 RUN, 2 power-save, 3 STOP.
- R2: While in RESET, `core_halt` is 1 and both `core_clk_en` and `periph_clk_en` are 0.
- R3: `pins_default` is 1 exactly while `mode_o` is RESET.
- R4: On the cycle after leaving RESET, `mode_o` is RUN and `pc_load_valid` is 1 for that single cycle, with `pc_load_addr` equal to 0x8000.
- R5: In RUN, `pm_req` high at an edge moves to power-save (code 2), where `clk_div_sel` is 1. In power-save, `pm_req` low at an edge returns to RUN. `clk_div_sel` is 0 in every other mode.
- R6: `stop_req` high at an edge in RUN or power-save moves to STOP (code 3), and it wins over `pm_req`. In STOP, `core_halt` is 1 and `core_clk_en` and `periph_clk_en` are 0.
- R7: `wut_clk_en` follows `wut_en` in every mode except RESET, STOP included. In RESET it is 0.
- R8: In STOP, `pm_req` and `stop_req` have no effect. The mode stays STOP until `wake_evt` or a reset request is seen at an edge.
- R9: `rst_cause` records the source of the latest reset: 0 power-on (also set by `rst_n`), 1 pin, 2 watchdog, 3 internal. When several requests are high together, the lowest code wins. The value holds until the next reset.
- R10: `core_halt` stays 1 for two full cycles after the last edge at which a reset request was high, and the mode becomes RUN at the following edge.
- R11: `wake_evt` at an edge in STOP restores the mode that was active when STOP was entered (RUN or power-save).
- R12: A reset request outranks every other input, including `wake_evt` in STOP and `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, counted as power-on |
| rq_power | input | 1 | Power-on / power-fail reset request |
| rq_pin | input | 1 | External pin reset request |
| rq_wdog | input | 1 | Watchdog timeout reset request |
| rq_soft | input | 1 | Internal system reset request |
| pm_req | input | 1 | Level request for reduced-clock mode |
| stop_req | input | 1 | Request to enter STOP |
| wake_evt | input | 1 | External stimulus that ends STOP |
| wut_en | input | 1 | Wake-up timer enable |
| mode_o | output | 2 | Current mode code |
| core_halt | output | 1 | Stops instruction execution |
| pins_default | output | 1 | Forces I/O pins to default state |
| clk_div_sel | output | 1 | Selects the reduced clock rate |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wut_clk_en | output | 1 | Wake-up timer clock enable |
| pc_load_valid | output | 1 | One-cycle strobe to load the restart address |
| pc_load_addr | output | 16 | Restart address (0x8000) |
| rst_cause | output | 2 | Source of the latest reset |

## Verification
Each reset source is driven alone and in overlapping groups. This separates the priority order of the cause register from plain last-writer behaviour. One-cycle and multi-cycle request pulses show that the release count starts from the final high edge and not the first. STOP is entered from RUN and from power-save and left by wake. This tells a true return-to-previous mode apart from a fixed return to RUN, and `pm_req` and `stop_req` toggle meanwhile to show they are ignored. A long stretch of random low-probability inputs then mixes resets into STOP and wake cycles, so precedence clashes show up against the reference model.

// File: rtl/rstmode_pkg.sv
package rstmode_pkg;
  typedef enum logic [1:0] {
    MODE_RESET   = 2'd0,
    MODE_RUN     = 2'd1,
    MODE_PWRSAVE = 2'd2,
    MODE_STOP    = 2'd3
  } mode_e;

  localparam int unsigned N_SRC = 4;
  localparam int unsigned CAUSE_W = $clog2(N_SRC);
endpackage

// File: rtl/rstmode_cause_enc.sv
module rstmode_cause_enc
  import rstmode_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  localparam int unsigned W = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src,
  output logic          any_src,
  output logic [W-1:0]  cause_q
);
  logic [W-1:0] enc;
  logic [W-1:0] cause_d;

  // lowest index carries highest priority
  always_comb begin
    enc = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (src[i]) enc = W'(i);
    end
  end

  assign any_src = |src;
  assign cause_d = any_src ? enc : cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  // R9: an idle cycle leaves the recorded cause untouched
  p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_src |=> $stable(cause_q));
endmodule

// File: rtl/rstmode_hold.sv
module rstmode_hold #(
  parameter int unsigned HOLD_CYC = 2,
  localparam int unsigned CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_src,
  input  logic in_reset,
  output logic release_o
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = any_src | (in_reset & (cnt_q != LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (any_src)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign release_o = in_reset & ~any_src & (cnt_q == LAST);

  // R10: a request cancels any pending release on the next cycle
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> !release_o || (HOLD_CYC == 1));
endmodule

// File: rtl/rstmode_fsm.sv
module rstmode_fsm
  import rstmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  any_src,
  input  logic  release_i,
  input  logic  pm_req,
  input  logic  stop_req,
  input  logic  wake_evt,
  output mode_e mode_q,
  output logic  pc_load_q
);
  mode_e mode_d;
  mode_e saved_q, saved_d;
  logic  pc_load_d;
  logic  saved_en;

  always_comb begin
    mode_d    = mode_q;
    saved_d   = saved_q;
    pc_load_d = 1'b0;
    if (any_src) begin
      mode_d = MODE_RESET;
    end else begin
      unique case (mode_q)
        MODE_RESET: if (release_i) begin
          mode_d    = MODE_RUN;
          pc_load_d = 1'b1;
        end
        MODE_RUN: begin
          if (stop_req) begin
            mode_d  = MODE_STOP;
            saved_d = MODE_RUN;
          end else if (pm_req) mode_d = MODE_PWRSAVE;
        end
        MODE_PWRSAVE: begin
          if (stop_req) begin
            mode_d  = MODE_STOP;
            saved_d = MODE_PWRSAVE;
          end else if (!pm_req) mode_d = MODE_RUN;
        end
        MODE_STOP: if (wake_evt) mode_d = saved_q;
        default: mode_d = MODE_RESET;
      endcase
    end
  end

  assign saved_en = (mode_d == MODE_STOP) && (mode_q != MODE_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RESET;
      pc_load_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      pc_load_q <= pc_load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        saved_q <= MODE_RUN;
    else if (saved_en) saved_q <= saved_d;
  end

  // R8: only wake or reset leaves STOP
  p_stop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && !wake_evt && !any_src) |=> mode_q == MODE_STOP);
  // R11: wake never lands in RESET or STOP
  p_wake_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && wake_evt && !any_src) |=>
      (mode_q == MODE_RUN || mode_q == MODE_PWRSAVE));
endmodule

// File: rtl/rstmode_outdec.sv
module rstmode_outdec
  import rstmode_pkg::*;
(
  input  mode_e mode,
  input  logic  wut_en,
  output logic  core_halt,
  output logic  pins_default,
  output logic  clk_div_sel,
  output logic  core_clk_en,
  output logic  periph_clk_en,
  output logic  wut_clk_en
);
  logic active;

  assign active        = (mode == MODE_RUN) || (mode == MODE_PWRSAVE);
  assign core_halt     = ~active;
  assign pins_default  = (mode == MODE_RESET);
  assign clk_div_sel   = (mode == MODE_PWRSAVE);
  assign core_clk_en   = active;
  assign periph_clk_en = active;
  assign wut_clk_en    = wut_en & (mode != MODE_RESET);
endmodule

// File: rtl/rstmode_ctrl.sv
module rstmode_ctrl
  import rstmode_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESTART_VEC = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_power,
  input  logic              rq_pin,
  input  logic              rq_wdog,
  input  logic              rq_soft,
  input  logic              pm_req,
  input  logic              stop_req,
  input  logic              wake_evt,
  input  logic              wut_en,
  output logic [1:0]        mode_o,
  output logic              core_halt,
  output logic              pins_default,
  output logic              clk_div_sel,
  output logic              core_clk_en,
  output logic              periph_clk_en,
  output logic              wut_clk_en,
  output logic              pc_load_valid,
  output logic [ADDR_W-1:0] pc_load_addr,
  output logic [1:0]        rst_cause
);
  logic [N_SRC-1:0] src;
  logic             any_src;
  logic             rel;
  mode_e            mode;

  assign src = {rq_soft, rq_wdog, rq_pin, rq_power};

  rstmode_cause_enc #(.NS(N_SRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .src(src),
    .any_src(any_src), .cause_q(rst_cause));

  rstmode_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .any_src(any_src),
    .in_reset(mode == MODE_RESET), .release_o(rel));

  rstmode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .any_src(any_src), .release_i(rel),
    .pm_req(pm_req), .stop_req(stop_req), .wake_evt(wake_evt),
    .mode_q(mode), .pc_load_q(pc_load_valid));

  rstmode_outdec u_dec (
    .mode(mode), .wut_en(wut_en),
    .core_halt(core_halt), .pins_default(pins_default),
    .clk_div_sel(clk_div_sel), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .wut_clk_en(wut_clk_en));

  assign mode_o       = mode;
  assign pc_load_addr = RESTART_VEC;

  // R1 / R12: any request wins and lands in RESET
  p_src_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> mode_o == 2'd0);
  // R2 / R3: core frozen and pins defaulted after a request
  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> core_halt && !core_clk_en && pins_default);
  // R10: halt lasts two cycles past the last request
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> core_halt ##1 core_halt);
  // R9: power request has top priority
  p_cause_pow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rq_power |=> rst_cause == 2'd0);
  // R4: strobe only as RUN begins, with the restart address
  p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_valid |-> mode_o == 2'd1 && pc_load_addr == 16'h8000 &&
      $past(mode_o) == 2'd0);
  // R6: stop gates core and peripheral clocks
  p_stop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !any_src && (mode_o == 2'd1 || mode_o == 2'd2)) |=>
      !core_clk_en && !periph_clk_en && core_halt);
  // R7: wake-up timer clock survives STOP
  p_wut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && wut_en) |-> wut_clk_en);
endmodule

// File: tb/tb_rstmode_ctrl.sv
module tb_rstmode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rq_power = 0, rq_pin = 0, rq_wdog = 0, rq_soft = 0;
  logic pm_req = 0, stop_req = 0, wake_evt = 0, wut_en = 0;
  logic [1:0]  mode_o;
  logic        core_halt, pins_default, clk_div_sel, core_clk_en;
  logic        periph_clk_en, wut_clk_en, pc_load_valid;
  logic [15:0] pc_load_addr;
  logic [1:0]  rst_cause;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_mode = 0, m_cnt = 0, m_saved = 1, m_cause = 0, m_pcv = 0;

  always #2 clk = ~clk;

  rstmode_ctrl dut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_saved = 1; m_cause = 0; m_pcv = 0;
    end else begin
      m_pcv = 0;
      if (rq_power || rq_pin || rq_wdog || rq_soft) begin
        m_mode = 0; m_cnt = 0;
        m_cause = rq_power ? 0 : rq_pin ? 1 : rq_wdog ? 2 : 3;
      end else begin
        case (m_mode)
          0: if (m_cnt == 1) begin m_mode = 1; m_pcv = 1; end
             else m_cnt = m_cnt + 1;
          1: if (stop_req) begin m_mode = 3; m_saved = 1; end
             else if (pm_req) m_mode = 2;
          2: if (stop_req) begin m_mode = 3; m_saved = 2; end
             else if (!pm_req) m_mode = 1;
          default: if (wake_evt) m_mode = m_saved;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int act_ok;
    act_ok = (m_mode == 1 || m_mode == 2) ? 1 : 0;
    vectors++;
    chk("R1 mode", mode_o, m_mode);
    chk("R2/R10 core_halt", core_halt, 1 - act_ok);
    chk("R2/R6 core_clk_en", core_clk_en, act_ok);
    chk("R6 periph_clk_en", periph_clk_en, act_ok);
    chk("R3 pins_default", pins_default, m_mode == 0);
    chk("R5 clk_div_sel", clk_div_sel, m_mode == 2);
    chk("R7 wut_clk_en", wut_clk_en, (m_mode != 0) && wut_en);
    chk("R4 pc_load_valid", pc_load_valid, m_pcv);
    chk("R4 pc_load_addr", pc_load_addr, 16'h8000);
    chk("R9 rst_cause", rst_cause, m_cause);
  endtask

  // v = {power, pin, wdog, soft, pm, stop, wake, wut}
  task automatic step(input logic [7:0] v);
    @(negedge clk);
    compare_all();
    {rq_power, rq_pin, rq_wdog, rq_soft, pm_req, stop_req, wake_evt, wut_en} = v;
    @(posedge clk);
  endtask

  task automatic idle(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) step(v);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle(3, 8'h00);                 // reset state, R9 power-on cause
    @(negedge clk); rst_n = 1'b1;
    idle(5, 8'h00);                 // R10 release, R4 strobe
    idle(3, 8'b0000_1000);          // R5 enter power-save
    idle(2, 8'b0000_0000);          // R5 back to RUN
    idle(2, 8'b0000_0101);          // R6 stop from RUN, R7 wut kept
    idle(4, 8'b0000_1101);          // R8 pm/stop ignored in STOP
    idle(1, 8'b0000_0011);          // R11 wake to RUN
    idle(2, 8'b0000_1000);          // power-save
    idle(1, 8'b0000_1100);          // R6 stop beats pm
    idle(3, 8'b0000_0000);          // R8 stay stopped, wut off
    idle(1, 8'b0000_0010);          // R11 wake to power-save
    idle(2, 8'b0000_1000);
    idle(1, 8'b0100_1000);          // R1 pin reset, cause 1
    idle(4, 8'b0000_0000);
    idle(3, 8'b0010_0001);          // R10 long watchdog pulse, cause 2
    idle(4, 8'b0000_0001);
    idle(1, 8'b0001_0000);          // internal, cause 3
    idle(1, 8'b0000_0000);
    idle(1, 8'b0001_0000);          // R10 retrigger during hold
    idle(4, 8'b0000_0000);
    idle(1, 8'b0111_0000);          // R9 pin beats watchdog and internal
    idle(4, 8'b0000_0000);
    idle(1, 8'b0011_0000);          // R9 watchdog beats internal
    idle(4, 8'b0000_0000);
    idle(1, 8'b1111_0000);          // R9 power beats all
    idle(4, 8'b0000_0000);
    idle(1, 8'b0000_0100);          // into STOP
    idle(1, 8'b0001_0010);          // R12 reset beats wake
    idle(4, 8'b0000_0000);
    idle(1, 8'b0010_0100);          // R12 reset beats stop
    idle(4, 8'b0000_0000);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] v;
      v = 8'h00;
      v[7] = ($urandom_range(0, 99) < 2);
      v[6] = ($urandom_range(0, 99) < 3);
      v[5] = ($urandom_range(0, 99) < 3);
      v[4] = ($urandom_range(0, 99) < 3);
      v[3] = ($urandom_range(0, 99) < 40);
      v[2] = ($urandom_range(0, 99) < 8);
      v[1] = ($urandom_range(0, 99) < 10);
      v[0] = ($urandom_range(0, 99) < 50);
      step(v);
    end
    step(8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule